// File: doc/BRIEF.md
# Carry-Conditional Relative Branch Unit

This block carries out one kind of instruction: a short relative jump that is taken only when the carry flag is set. It receives a 16-bit instruction word, the carry flag and the byte address of that instruction. It recognises its own opcode in the upper byte. It then works out where the program counter goes next. The lower byte is a signed word offset. The jump lands at the instruction address plus two plus twice the offset, wrapped to the program counter width.

When the jump is taken, the unit asks the program counter to load the target and raises a flush request. The instruction already fetched behind the branch is then dropped. The unit also spends one extra cycle as an empty slot, shown on `busy`, and ignores any instruction issued during that slot. When the jump is not taken, the instruction completes in a single cycle. The unit reports the sequential address, two bytes on, and requests neither a load nor a flush. The branch never writes any status flag.

Top module: `carry_branch_unit`

## Requirements
- R1: The unit acts as a branch only when instruction bits 15:8 equal 8'hE2. Any other upper byte is never taken, whatever the carry, and reports `next_pc` = `pc` + 2.
- R2: For an accepted branch with `carry` = 1, `next_pc` equals `pc` + 2 + 2·n, where n is bits 7:0 read as two's complement. The value appears in the cycle after the issuing clock edge.
- R3: Offsets at the edges of the range are exact: n = -1 gives `pc` itself, n = 127 gives `pc` + 256, and n = -128 gives `pc` - 254.
- R4: Target arithmetic wraps modulo 2^21, and bit 0 of `next_pc` is always 0.
- R5: A taken branch raises `pc_load` and `flush` for exactly one cycle, the cycle after the issuing edge.
- R6: `busy` is high during that single empty cycle. An `issue` presented while `busy` is high is ignored: no flush, no load, and `next_pc` unchanged.
- R7: An accepted branch with `carry` = 0 takes one cycle. It gives `next_pc` = `pc` + 2 with `pc_load`, `flush` and `busy` all low, and a new issue is accepted on the very next edge.
- R8: After reset, `next_pc` is 0 and `pc_load`, `flush` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| carry | input | 1 | Carry flag |
| pc | input | 21 | Byte address of the presented instruction |
| next_pc | output | 21 | Address execution continues from |
| pc_load | output | 1 | Program counter must load `next_pc` (taken branch) |
| flush | output | 1 | Discard the prefetched instruction |
| busy | output | 1 | Empty cycle of a taken branch in progress |

## Verification
Every result is registered once. `next_pc`, `pc_load`, `flush` and `busy` reflect an issue in the cycle after the clock edge that accepts it. `busy`, `flush` and `pc_load` return low one further edge later. Each scenario task drives its inputs on a falling edge and samples just after the next rising edge. For taken branches it samples again one edge later, to confirm the single empty cycle and that a second issue made during it changes nothing.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_DEAD = 1'b1
  } cbu_state_e;

  typedef struct packed {
    logic hit;
    logic take;
  } cbu_dec_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int OFF_W   = 8,
  parameter logic [INSTR_W-OFF_W-1:0] OPCODE = 8'hE2
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               carry,
  output cbu_dec_t           dec,
  output logic [OFF_W-1:0]   offset
);
  localparam int OPC_W = INSTR_W - OFF_W;

  logic [OPC_W-1:0] opc_field;

  always_comb begin
    opc_field = instr[INSTR_W-1:OFF_W];
    offset    = instr[OFF_W-1:0];
    dec.hit   = (opc_field == OPCODE);
    dec.take  = dec.hit && carry;
  end
endmodule

// File: rtl/cbu_target.sv
module cbu_target #(
  parameter int PC_W  = 21,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  target,
  output logic [PC_W-1:0]  seq_pc
);
  localparam int EXT_W = PC_W - OFF_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0] ext_off;
  logic [PC_W-1:0] sum_t;
  logic [PC_W-1:0] sum_s;

  generate
    if (EXT_W > 0) begin : g_ext
      always_comb ext_off = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      always_comb ext_off = offset[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    sum_s  = pc + STEP;
    sum_t  = sum_s + (ext_off << 1);
    seq_pc = {sum_s[PC_W-1:1], 1'b0};
    target = {sum_t[PC_W-1:1], 1'b0};
  end
endmodule

// File: rtl/cbu_seq.sv
module cbu_seq
  import cbu_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  cbu_dec_t        dec,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pc_load,
  output logic            flush,
  output logic            busy
);
  logic            rs_meta, srst_n;
  cbu_state_e      state_q, state_d;
  logic            accept;
  logic            npc_en;
  logic [PC_W-1:0] npc_d;
  logic            load_d, flush_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      srst_n  <= rs_meta;
    end
  end

  always_comb begin
    accept  = issue && (state_q == ST_RUN);
    state_d = ST_RUN;
    npc_en  = accept;
    npc_d   = dec.take ? target : seq_pc;
    load_d  = accept && dec.take;
    flush_d = accept && dec.take;
    if (accept && dec.take) state_d = ST_DEAD;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_RUN;
      pc_load <= 1'b0;
      flush   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_load <= load_d;
      flush   <= flush_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) next_pc <= '0;
    else if (npc_en) next_pc <= npc_d;
  end

  always_comb busy = (state_q == ST_DEAD);

  a_r5_flush_single: assert property (@(posedge clk) disable iff (!srst_n)
    flush |=> !flush);
  a_r6_flush_in_dead: assert property (@(posedge clk) disable iff (!srst_n)
    flush |-> busy);
  a_r6_dead_ignores: assert property (@(posedge clk) disable iff (!srst_n)
    busy |=> (!flush && !pc_load && $stable(next_pc)));
  a_r5_flush_cause: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(flush) |-> $past(issue && dec.take));
endmodule

// File: rtl/carry_branch_unit.sv
module carry_branch_unit
  import cbu_pkg::*;
#(
  parameter int PC_W    = 21,
  parameter int INSTR_W = 16,
  parameter int OFF_W   = 8,
  parameter logic [INSTR_W-OFF_W-1:0] OPCODE = 8'hE2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [INSTR_W-1:0] instr,
  input  logic               carry,
  input  logic [PC_W-1:0]    pc,
  output logic [PC_W-1:0]    next_pc,
  output logic               pc_load,
  output logic               flush,
  output logic               busy
);
  cbu_dec_t        dec;
  logic [OFF_W-1:0] offset;
  logic [PC_W-1:0]  target, seq_pc;

  cbu_decode #(.INSTR_W(INSTR_W), .OFF_W(OFF_W), .OPCODE(OPCODE)) u_dec (
    .instr(instr), .carry(carry), .dec(dec), .offset(offset)
  );

  cbu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc(pc), .offset(offset), .target(target), .seq_pc(seq_pc)
  );

  cbu_seq #(.PC_W(PC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .issue(issue), .dec(dec),
    .target(target), .seq_pc(seq_pc),
    .next_pc(next_pc), .pc_load(pc_load), .flush(flush), .busy(busy)
  );

  a_r4_even_pc: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc[0] == 1'b0);
  a_r7_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && !carry) |=> (!flush && !pc_load));
endmodule

// File: tb/sim_carry_branch_unit.sv
module sim_carry_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 21;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            issue;
  logic [15:0]     instr;
  logic            carry;
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] next_pc;
  logic            pc_load, flush, busy;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .carry(carry),
    .pc(pc), .next_pc(next_pc), .pc_load(pc_load), .flush(flush), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] model(input logic [PC_W-1:0] a, input logic [7:0] n);
    int signed s;
    s = $signed(n);
    return PC_W'(int'(a) + 2 + 2 * s);
  endfunction

  task automatic present(input logic [15:0] w, input logic c, input logic [PC_W-1:0] a);
    @(negedge clk);
    issue = 1'b1; instr = w; carry = c; pc = a;
    @(posedge clk); #1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic run_taken(input string req, input logic [PC_W-1:0] a, input logic [7:0] n);
    logic [PC_W-1:0] exp_t;
    exp_t = model(a, n);
    @(negedge clk);
    issue = 1'b1; instr = {8'hE2, n}; carry = 1'b1; pc = a;
    @(posedge clk); #1;
    chk({req, " target"}, 32'(next_pc), 32'(exp_t));
    chk("R5 load", 32'(pc_load), 1);
    chk("R5 flush", 32'(flush), 1);
    chk("R6 busy", 32'(busy), 1);
    @(negedge clk); issue = 1'b0;
    @(posedge clk); #1;
    chk("R5 flush drops", 32'(flush), 0);
    chk("R6 busy drops", 32'(busy), 0);
  endtask

  task automatic test_reset();
    chk("R8 next_pc", 32'(next_pc), 0);
    chk("R8 pc_load", 32'(pc_load), 0);
    chk("R8 flush", 32'(flush), 0);
    chk("R8 busy", 32'(busy), 0);
  endtask

  task automatic test_not_taken();
    present({8'hE2, 8'h05}, 1'b0, 21'h000400);
    chk("R7 seq pc", 32'(next_pc), 32'h402);
    chk("R7 no flush", 32'(flush), 0);
    chk("R7 no load", 32'(pc_load), 0);
    chk("R7 no busy", 32'(busy), 0);
    present({8'hE2, 8'hFF}, 1'b1, 21'h000500);
    chk("R7 next accepted", 32'(next_pc), 32'h500);
  endtask

  task automatic test_wrong_opcode();
    present({8'hE3, 8'h10}, 1'b1, 21'h000800);
    chk("R1 other op pc", 32'(next_pc), 32'h802);
    chk("R1 other op flush", 32'(flush), 0);
    present({8'h62, 8'h10}, 1'b1, 21'h000900);
    chk("R1 other op2 pc", 32'(next_pc), 32'h902);
    chk("R1 other op2 load", 32'(pc_load), 0);
  endtask

  task automatic test_busy_ignore();
    @(negedge clk);
    issue = 1'b1; instr = 16'hE203; carry = 1'b1; pc = 21'h001000;
    @(posedge clk); #1;
    chk("R2 target", 32'(next_pc), 32'h1008);
    @(negedge clk);
    instr = 16'hE240; pc = 21'h002000;
    @(posedge clk); #1;
    chk("R6 ignored flush", 32'(flush), 0);
    chk("R6 ignored load", 32'(pc_load), 0);
    chk("R6 ignored pc", 32'(next_pc), 32'h1008);
    @(negedge clk); issue = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; issue = 1'b0; instr = '0; carry = 1'b0; pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    run_taken("R2", 21'h000100, 8'h05);
    run_taken("R3 n=-1", 21'h000200, 8'hFF);
    run_taken("R3 n=127", 21'h000300, 8'h7F);
    run_taken("R3 n=-128", 21'h010000, 8'h80);
    run_taken("R4 wrap up", 21'h1FFFFE, 8'h01);
    run_taken("R4 wrap down", 21'h000004, 8'hF0);
    test_not_taken();
    test_wrong_opcode();
    test_busy_ignore();
    chk("R4 even", 32'(next_pc[0]), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule